// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a small synchronous SRAM with a pipelined read path and late write data. It lets a bus master alternate reads and writes on consecutive clocks with no idle cycles. The data word is split into byte lanes, each holding eight data bits and one parity bit. Every lane has its own active-low write strobe. The external bidirectional data pins are modelled as a separate input bus, a registered output bus and an output-drive flag.

Commands are sampled on rising clock edges, but only when the active-low clock enable is low. A stalled edge freezes the whole pipeline. A load cycle samples a new address and direction. An advance cycle steps a short internal burst counter over the low address bits, in linear or interleaved order as chosen by a static strap. Write data follows its address by two enabled clocks. A read whose array access coincides with the write-data capture of an older write to the same word returns the merged, newer data.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge the pipeline empties, and after reset `dq_oe` is 0 until a read has completed.
- R2: An edge with `clk_en_n` high is ignored. Every input, including `dq_in`, is disregarded, no array word changes, and `dq_out` and `dq_oe` hold.
- R3: A load cycle (`adv_ld` = 0) selects the device only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. Any other combination deselects it and starts no access.
- R4: A read loaded at enabled edge k drives `dq_out` with the addressed word, and raises `dq_oe`, after enabled edge k+1.
- R5: A write loaded at enabled edge k takes its data from `dq_in` at enabled edge k+2. Reads and writes may alternate on every enabled edge with no idle cycle.
- R6: `lane_wr_n[l]` = 0 in a write's command cycle lets lane l, bits [9l+8:9l] (8 data bits plus parity), be written. A lane whose bit is 1 keeps its old contents.
- R7: An advance cycle (`adv_ld` = 1) continues the current access at the next beat. The upper address bits stay fixed and beat n uses low bits (base + n) mod 4 when `order_ilv` = 0. The counter wraps after four beats.
- R8: With `order_ilv` = 1, beat n of a burst uses low address bits base XOR n.
- R9: An advance cycle that follows a deselect starts no access, and it neither reads nor writes.
- R10: `dq_oe` is 0 during a write's data cycle, on the first cycle after a deselect and while deselected, for any value of `oe_n`.
- R11: `oe_n` = 1 forces `dq_oe` to 0 at once, without a clock edge.
- R12: A read of the word whose write data is captured at the same edge that forms the read result returns that new data in the written lanes and the array's old data in the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low pipeline reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls the pipeline |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write on a load cycle |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address |
| order_ilv | input | 1 | Burst order strap: 1 interleaved (default tie-off), 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Data in from the pins |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Pin drive enable |

## Verification
The bench targets the same-word read that lands on the edge where an older write's data is captured. A design without forwarding would return stale lanes there, and one that ignored the lane strobes would return new data in all lanes. It stalls the clock while garbage write commands and data are on the pins, with both a finished read and a pending write in flight. A design that let the stall through would move the pipeline, corrupt a word or drop the delayed write data. Bursts are checked through their wrap point in both orders, and an advance after a deselect is checked to do nothing. The deselect and write-data cycles are checked to leave the pins undriven even with `oe_n` low.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_kind_e;

endpackage

// File: rtl/zt_sram_burst.sv
// Low-address generator for one burst beat.
module zt_sram_burst #(
   parameter int BURST_BITS = 2
) (
   input  logic [BURST_BITS-1:0] start,
   input  logic [BURST_BITS-1:0] beat,
   input  logic                  interleave,
   output logic [BURST_BITS-1:0] lo
);
   logic [BURST_BITS-1:0] lin_lo;
   logic [BURST_BITS-1:0] ilv_lo;

   assign lin_lo = start + beat;   // wraps modulo the burst length
   assign ilv_lo = start ^ beat;
   assign lo     = interleave ? ilv_lo : lin_lo;
endmodule

// File: rtl/zt_sram_cmd.sv
// Command sampling, select decode, burst counter and the two command stages.
module zt_sram_cmd
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 8,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_n,
   input  logic              adv_ld,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  lane_wr_n,
   output op_kind_e          s1_kind,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_mask,
   output op_kind_e          s2_kind,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_mask
);
   localparam int HI_W = ADDR_W - BURST_BITS;

   op_kind_e              burst_kind;
   op_kind_e              load_kind;
   logic [ADDR_W-1:0]     base;
   logic [BURST_BITS-1:0] beat;
   logic [BURST_BITS-1:0] beat_nx;
   logic [BURST_BITS-1:0] lo_nx;
   logic                  picked;

   assign picked  = !sel_a_n && sel_b && !sel_c_n;
   assign beat_nx = beat + 1'b1;

   always_comb begin
      load_kind = wr_n ? OP_READ : OP_WRITE;
   end

   zt_sram_burst #(
      .BURST_BITS(BURST_BITS)
   ) u_burst (
      .start     (base[BURST_BITS-1:0]),
      .beat      (beat_nx),
      .interleave(order_ilv),
      .lo        (lo_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_kind <= OP_IDLE;
         base       <= '0;
         beat       <= '0;
         s1_kind    <= OP_IDLE;
         s1_addr    <= '0;
         s1_mask    <= '1;
         s2_kind    <= OP_IDLE;
         s2_addr    <= '0;
         s2_mask    <= '1;
      end else if (en) begin
         s2_kind <= s1_kind;
         s2_addr <= s1_addr;
         s2_mask <= s1_mask;
         s1_mask <= lane_wr_n;
         if (!adv_ld) begin
            if (picked) begin
               burst_kind <= load_kind;
               s1_kind    <= load_kind;
               base       <= addr;
               beat       <= '0;
               s1_addr    <= addr;
            end else begin
               burst_kind <= OP_IDLE;
               s1_kind    <= OP_IDLE;
            end
         end else if (burst_kind != OP_IDLE) begin
            beat    <= beat_nx;
            s1_kind <= burst_kind;
            s1_addr <= {base[ADDR_W-1 -: HI_W], lo_nx};
         end else begin
            s1_kind <= OP_IDLE;
         end
      end
   end
endmodule

// File: rtl/zt_sram_array.sv
// Lane-banked storage, late write, forwarding and the read output register.
module zt_sram_array
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  op_kind_e                rd_kind,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  op_kind_e                wr_kind,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic                    rd_valid,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              rd_go;
   logic              wr_go;
   logic              same_word;
   logic [DATA_W-1:0] rd_word;

   assign rd_go     = (rd_kind == OP_READ);
   assign wr_go     = (wr_kind == OP_WRITE);
   assign same_word = wr_go && (wr_addr == rd_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] din;

      assign din = wr_data[l*LANE_W +: LANE_W];

      always_ff @(posedge clk) begin
         if (en && wr_go && !wr_mask[l]) begin
            bank[wr_addr] <= din;
         end
      end

      assign rd_word[l*LANE_W +: LANE_W] =
         (same_word && !wr_mask[l]) ? din : bank[rd_addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else if (en) begin
         rd_valid <= rd_go;
         if (rd_go) begin
            rd_data <= rd_word;
         end
      end
   end
endmodule

// File: rtl/zt_sram.sv
// Pipelined zero-turnaround SRAM model, top level.
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 8,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    adv_ld,
   input  logic                    order_ilv,
   input  logic                    oe_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (BURST_BITS < 1 || BURST_BITS >= ADDR_W) begin : g_bad_burst
      $error("zt_sram: BURST_BITS must be at least 1 and below ADDR_W");
   end
   if (LANES < 1 || LANE_W < 2) begin : g_bad_lane
      $error("zt_sram: need at least one lane of two or more bits");
   end
   if (ADDR_W > 12) begin : g_bad_depth
      $error("zt_sram: ADDR_W too large for a register array");
   end

   op_kind_e          s1_kind;
   op_kind_e          s2_kind;
   logic [ADDR_W-1:0] s1_addr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s1_mask;
   logic [LANES-1:0]  s2_mask;
   logic              rd_valid;
   logic              en;

   assign en = !clk_en_n;

   zt_sram_cmd #(
      .ADDR_W    (ADDR_W),
      .LANES     (LANES),
      .BURST_BITS(BURST_BITS)
   ) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .sel_a_n  (sel_a_n),
      .sel_b    (sel_b),
      .sel_c_n  (sel_c_n),
      .wr_n     (wr_n),
      .adv_ld   (adv_ld),
      .order_ilv(order_ilv),
      .addr     (addr),
      .lane_wr_n(lane_wr_n),
      .s1_kind  (s1_kind),
      .s1_addr  (s1_addr),
      .s1_mask  (s1_mask),
      .s2_kind  (s2_kind),
      .s2_addr  (s2_addr),
      .s2_mask  (s2_mask)
   );

   zt_sram_array #(
      .ADDR_W(ADDR_W),
      .LANES (LANES),
      .LANE_W(LANE_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .rd_kind (s1_kind),
      .rd_addr (s1_addr),
      .wr_kind (s2_kind),
      .wr_addr (s2_addr),
      .wr_mask (s2_mask),
      .wr_data (dq_in),
      .rd_valid(rd_valid),
      .rd_data (dq_out)
   );

   // Drive only on a completed read; oe_n gates asynchronously.
   assign dq_oe = rd_valid && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
// Property checker for zt_sram, attached by bind.
module zt_sram_chk
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2,
   parameter int DATA_W     = 72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              adv_ld,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              oe_n,
   input logic              dq_oe,
   input logic              rd_valid,
   input logic [DATA_W-1:0] dq_out,
   input op_kind_e          s1_kind,
   input logic [ADDR_W-1:0] s1_addr,
   input op_kind_e          s2_kind
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(clk_en_n) |-> $stable(rd_valid) && $stable(dq_out)); // R2

   AST_SELECT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!clk_en_n) && $past(!adv_ld)
      && !$past(!sel_a_n && sel_b && !sel_c_n) |-> s1_kind == OP_IDLE); // R3

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!clk_en_n) && $past(s1_kind) == OP_READ |-> rd_valid); // R4

   AST_BURST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!clk_en_n && adv_ld) && s1_kind != OP_IDLE
      |-> s1_addr[ADDR_W-1:BURST_BITS] == $past(s1_addr[ADDR_W-1:BURST_BITS])); // R7

   AST_ADV_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!clk_en_n && adv_ld) && $past(s1_kind) == OP_IDLE
      |-> s1_kind == OP_IDLE); // R9

   AST_WRDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      s2_kind == OP_WRITE |-> !dq_oe); // R10

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!clk_en_n) && $past(s1_kind) == OP_IDLE |-> !rd_valid); // R10

   AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe); // R11
endmodule

bind zt_sram zt_sram_chk #(
   .ADDR_W    (ADDR_W),
   .BURST_BITS(BURST_BITS),
   .DATA_W    (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .adv_ld   (adv_ld),
   .sel_a_n  (sel_a_n),
   .sel_b    (sel_b),
   .sel_c_n  (sel_c_n),
   .oe_n     (oe_n),
   .dq_oe    (dq_oe),
   .rd_valid (rd_valid),
   .dq_out   (dq_out),
   .s1_kind  (s1_kind),
   .s1_addr  (s1_addr),
   .s2_kind  (s2_kind)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
   localparam int CLK_PERIOD = 10;
   localparam int K_DES = 0;
   localparam int K_RD  = 1;
   localparam int K_WR  = 2;
   localparam int K_ADV = 3;
   localparam int NV    = 21;

   // {kind[1:0], addr[5:0], lane mask[7:0], data seed[7:0]}
   localparam logic [23:0] VEC [NV] = '{
      {2'd2, 6'h10, 8'h00, 8'h11},  // full write
      {2'd2, 6'h11, 8'h00, 8'h22},
      {2'd1, 6'h10, 8'h00, 8'h00},  // R5 read between writes
      {2'd2, 6'h12, 8'h00, 8'h33},
      {2'd1, 6'h11, 8'h00, 8'h00},
      {2'd2, 6'h10, 8'hF0, 8'h44},  // R6 lanes 0..3 only
      {2'd1, 6'h10, 8'h00, 8'h00},  // R12 forwarded merge
      {2'd1, 6'h12, 8'h00, 8'h00},
      {2'd0, 6'h00, 8'h00, 8'h00},  // deselect
      {2'd3, 6'h00, 8'h00, 8'h00},  // R9 advance after deselect
      {2'd1, 6'h10, 8'h00, 8'h00},  // first read after deselect
      {2'd2, 6'h22, 8'h00, 8'h55},  // R7 linear write burst
      {2'd3, 6'h00, 8'h00, 8'h66},
      {2'd3, 6'h00, 8'h00, 8'h77},
      {2'd3, 6'h00, 8'h00, 8'h88},
      {2'd1, 6'h22, 8'h00, 8'h00},  // R7 linear read burst
      {2'd3, 6'h00, 8'h00, 8'h00},
      {2'd3, 6'h00, 8'h00, 8'h00},
      {2'd3, 6'h00, 8'h00, 8'h00},
      {2'd3, 6'h00, 8'h00, 8'h00},  // R7 fifth beat wraps to base
      {2'd0, 6'h00, 8'h00, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n, clk_en_n, sel_a_n, sel_b, sel_c_n, wr_n, adv_ld, order_ilv, oe_n;
   logic [7:0]  lane_wr_n;
   logic [5:0]  addr;
   logic [71:0] dq_in, dq_out;
   logic        dq_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model
   logic [71:0] shadow [64];
   int          m_kind = 0;
   logic [5:0]  m_base = '0;
   logic [1:0]  m_cnt  = '0;
   logic        m_ilv  = 1'b0;
   int          sn     = 0;
   int          r_kind [4];
   logic [5:0]  r_addr [4];
   logic [7:0]  r_mask [4];
   logic [71:0] r_data [4];
   string       r_tag  [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   zt_sram dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .adv_ld(adv_ld),
      .order_ilv(order_ilv), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic logic [71:0] pat(input logic [7:0] seed);
      logic [71:0] w;
      logic [7:0]  v;
      w = '0;
      for (int l = 0; l < 8; l++) begin
         v = seed + 8'(l * 29);
         w[l*9 +: 9] = {^v, v};
      end
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_pins();
      clk_en_n = 1'b0; adv_ld = 1'b0; {sel_a_n, sel_b, sel_c_n} = 3'b110;
      wr_n = 1'b1; lane_wr_n = '1; addr = '0; dq_in = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_pins();
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(dq_oe === 1'b0, "R1 reset", {71'd0, dq_oe}, 72'd0);
      m_kind = 0;
      sn = 0;
      for (int i = 0; i < 4; i++) r_kind[i] = 0;
   endtask

   // One enabled cycle; checks the op issued on the previous step.
   task automatic step(input int kind, input logic [5:0] a, input logic [7:0] mask,
                       input logic [7:0] seed, input string tag, input logic [2:0] ce);
      int p, q;
      logic [5:0] ea;
      ea = a;
      if (kind == K_ADV) begin
         if (m_kind != 0) begin
            m_cnt = m_cnt + 2'd1;
            ea = {m_base[5:2], m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
         end
      end else if (kind != K_DES && ce == 3'b010) begin
         m_kind = (kind == K_WR) ? 2 : 1;
         m_base = a;
         m_cnt  = 2'd0;
      end else begin
         m_kind = 0;
      end
      p = sn % 4;
      r_kind[p] = m_kind; r_addr[p] = ea; r_mask[p] = mask;
      r_data[p] = pat(seed); r_tag[p] = tag;
      @(negedge clk);
      clk_en_n = 1'b0;
      adv_ld = (kind == K_ADV);
      {sel_a_n, sel_b, sel_c_n} = (kind == K_DES) ? 3'b110 : ce;
      wr_n = (kind != K_WR);
      addr = a;
      lane_wr_n = mask;
      order_ilv = m_ilv;
      dq_in = {8{9'h15A}};
      if (sn >= 2) begin
         q = (sn - 2) % 4;
         if (r_kind[q] == 2) begin
            dq_in = r_data[q];
            for (int l = 0; l < 8; l++)
               if (!r_mask[q][l]) shadow[r_addr[q]][l*9 +: 9] = r_data[q][l*9 +: 9];
         end
      end
      @(posedge clk); #1;
      if (sn >= 1) begin
         q = (sn - 1) % 4;
         if (r_kind[q] == 1)
            chk(dq_oe === 1'b1 && dq_out === shadow[r_addr[q]], r_tag[q], dq_out, shadow[r_addr[q]]);
         else
            chk(dq_oe === 1'b0, r_tag[q], {71'd0, dq_oe}, 72'd0);
      end
      sn++;
   endtask

   // Stalled edges with a hostile command and data on the pins.
   task automatic stall(input int n, input string tag);
      logic [71:0] h_out;
      logic        h_oe;
      h_out = dq_out;
      h_oe  = dq_oe;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         clk_en_n = 1'b1; adv_ld = 1'b0; {sel_a_n, sel_b, sel_c_n} = 3'b010;
         wr_n = 1'b0; lane_wr_n = '0; addr = 6'h10; dq_in = {9{8'hEE}};
         @(posedge clk); #1;
         chk(dq_oe === h_oe && dq_out === h_out, tag, dq_out, h_out);
      end
   endtask

   initial begin
      rst_n = 1'b0; oe_n = 1'b0; order_ilv = 1'b0;
      idle_pins();
      for (int i = 0; i < 64; i++) shadow[i] = '0;
      do_reset();                                        // R1

      for (int i = 0; i < NV; i++) begin
         step(int'(VEC[i][23:22]), VEC[i][21:16], VEC[i][15:8], VEC[i][7:0],
              (VEC[i][23:22] == 2'd1) ? "R4 read data" : "R10 no drive", 3'b010);
      end
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      step(K_RD, 6'h20, 8'h00, 8'h00, "R7 read", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      chk(dq_out === pat(8'h77), "R7 linear beat 2 at 0x20", dq_out, pat(8'h77));

      // R2: stall with completed read on the bus, then with a write in flight
      step(K_RD, 6'h10, 8'h00, 8'h00, "R2 read", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R2 idle", 3'b010);
      stall(3, "R2 hold");
      step(K_DES, 6'h00, 8'h00, 8'h00, "R2 idle", 3'b010);
      step(K_WR, 6'h15, 8'h00, 8'h99, "R2 write", 3'b010);
      stall(2, "R2 hold");
      step(K_DES, 6'h00, 8'h00, 8'h00, "R2 idle", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R2 idle", 3'b010);
      step(K_RD, 6'h10, 8'h00, 8'h00, "R2 word untouched", 3'b010);
      step(K_RD, 6'h15, 8'h00, 8'h00, "R2 delayed data", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      chk(dq_out === pat(8'h99), "R5 late data at 0x15", dq_out, pat(8'h99));

      // R3: each wrong select combination starts nothing
      step(K_RD, 6'h11, 8'h00, 8'h00, "R3 sel_a_n high", 3'b110);
      step(K_RD, 6'h11, 8'h00, 8'h00, "R3 sel_b low", 3'b000);
      step(K_RD, 6'h11, 8'h00, 8'h00, "R3 sel_c_n high", 3'b011);
      step(K_RD, 6'h11, 8'h00, 8'h00, "R3 selected", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);

      // R11: output enable acts without a clock
      step(K_RD, 6'h11, 8'h00, 8'h00, "R11 read", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      #1 oe_n = 1'b1;
      #1 chk(dq_oe === 1'b0, "R11 oe_n high", {71'd0, dq_oe}, 72'd0);
      oe_n = 1'b0;
      #1 chk(dq_oe === 1'b1, "R11 oe_n low", {71'd0, dq_oe}, 72'd1);

      // R8: interleaved burst from low bits 01 visits 01,00,11,10
      m_ilv = 1'b1;
      step(K_WR, 6'h31, 8'h00, 8'hA1, "R8 write", 3'b010);
      step(K_ADV, 6'h00, 8'h00, 8'hA2, "R8 write", 3'b010);
      step(K_ADV, 6'h00, 8'h00, 8'hA3, "R8 write", 3'b010);
      step(K_ADV, 6'h00, 8'h00, 8'hA4, "R8 write", 3'b010);
      step(K_RD, 6'h31, 8'h00, 8'h00, "R8 read", 3'b010);
      step(K_ADV, 6'h00, 8'h00, 8'h00, "R8 read", 3'b010);
      step(K_ADV, 6'h00, 8'h00, 8'h00, "R8 read", 3'b010);
      step(K_ADV, 6'h00, 8'h00, 8'h00, "R8 read", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      step(K_RD, 6'h30, 8'h00, 8'h00, "R8 read", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      chk(dq_out === pat(8'hA2), "R8 beat 1 at 0x30", dq_out, pat(8'hA2));
      step(K_RD, 6'h32, 8'h00, 8'h00, "R8 read", 3'b010);
      step(K_DES, 6'h00, 8'h00, 8'h00, "R10 no drive", 3'b010);
      chk(dq_out === pat(8'hA4), "R8 beat 3 at 0x32", dq_out, pat(8'hA4));

      // R1: reset in the middle of a read
      step(K_RD, 6'h10, 8'h00, 8'h00, "R1 read", 3'b010);
      do_reset();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule